// File: doc/BRIEF.md
# Serial-In Shift Register with Output Latch

This block takes a serial bit stream into a chain of flip-flops on the rising edge of its shift clock. On the rising edge of a separate storage clock it copies the whole chain at once into a holding register. The holding register drives a parallel word. A companion enable says whether the word is being driven or left at high impedance, so a wrapper at the pad ring can turn the pair into real tri-state pins.

The last stage of the chain is brought out as a cascade bit. Feeding it into the serial input of a second block gives a chain twice as long. The active-low master reset acts at once on the chain flip-flops. It never touches the holding register.

The output stage has two named modes. In `OUT_DRIVE` the enable input is low and the word is driven. In `OUT_HIZ` the enable input is high and the word is released. The block moves between the two as soon as the enable input changes, with no clock involved. The width is a parameter with a default of 8.

Top module: `ser_latch_shifter`

## Requirements
- R1: On each rising edge of `shift_clk` while `rst_n` is high, `sdi` enters stage 0 and each stage i (1..7) takes the value stage i-1 held before the edge.
- R2: On each rising edge of `store_clk`, the holding register takes all eight stage values at once, with stage i going to `par_q[i]`. Between those edges `par_q` does not change.
- R3: `cas_out` always equals stage 7, so after a shift it shows what stage 6 held before that shift.
- R4: While `rst_n` is low, every stage is 0 at once without any clock edge, and `cas_out` is 0. The holding register, seen on `par_q`, keeps its value.
- R5: A rising edge of `store_clk` while `rst_n` is low loads all zeros into the holding register.
- R6: `par_en` is 1 (mode `OUT_DRIVE`) exactly when `oe_n` is 0, and 0 (mode `OUT_HIZ`) when `oe_n` is 1. `oe_n` changes neither `par_q` nor `cas_out`.
- R7: When `shift_clk` and `store_clk` rise together, the holding register takes the stage values from before that edge, so it lags the chain by one shift.
- R8: With `cas_out` of one block wired to `sdi` of a second block sharing both clocks, the pair forms a 16-stage chain. The first block holds chain bits 0..7 and the second holds bits 8..15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sdi | input | 1 | Serial data into stage 0 |
| shift_clk | input | 1 | Shift chain clock, rising edge |
| store_clk | input | 1 | Holding register clock, rising edge |
| rst_n | input | 1 | Asynchronous clear of the shift chain, active low |
| oe_n | input | 1 | Parallel output enable, active low |
| par_q | output | 8 | Holding register contents |
| par_en | output | 1 | High when `par_q` should be driven onto the pins |
| cas_out | output | 1 | Last shift stage, for chaining |

## Verification
The hardest situation to reach is a storage edge that lands while reset is holding the chain clear. Two things must be seen together: zeros reach the holding register, and a reset with no storage edge leaves it untouched. The bench first loads a known non-zero word into the holding register and drops reset. It checks that the word survives, then pulses the storage clock with reset still low. The bench also raises both clocks in the same cycle to show the one-shift lag, and it runs a 16-bit pattern through two chained instances.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    localparam int unsigned SSR_WIDTH_DEFAULT = 8;

    typedef enum logic {
        OUT_HIZ   = 1'b0,
        OUT_DRIVE = 1'b1
    } out_mode_e;
endpackage

// File: rtl/ssr_shift_chain.sv
module ssr_shift_chain #(
    parameter int unsigned WIDTH = ssr_pkg::SSR_WIDTH_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sdi,
    output logic [WIDTH-1:0] stages
);
    localparam int unsigned LAST = WIDTH - 1;

    for (genvar g = 0; g < WIDTH; g++) begin : g_stage
        logic nxt;
        if (g == 0) begin : g_head
            assign nxt = sdi;
        end else begin : g_body
            assign nxt = stages[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stages[g] <= 1'b0;
            end else begin
                stages[g] <= nxt;
            end
        end
    end

    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (stages == {$past(stages[LAST-1:0]), $past(sdi)}));  // R1

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |-> (stages == '0));  // R4
endmodule

// File: rtl/ssr_hold_reg.sv
module ssr_hold_reg #(
    parameter int unsigned WIDTH = ssr_pkg::SSR_WIDTH_DEFAULT
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        q <= d;
    end
endmodule

// File: rtl/ssr_out_stage.sv
module ssr_out_stage #(
    parameter int unsigned WIDTH = ssr_pkg::SSR_WIDTH_DEFAULT
) (
    input  logic             oe_n,
    input  logic [WIDTH-1:0] held,
    output logic [WIDTH-1:0] par_q,
    output logic             par_en
);
    import ssr_pkg::*;

    out_mode_e mode;

    always_comb begin
        mode = oe_n ? OUT_HIZ : OUT_DRIVE;
    end

    always_comb begin
        par_q = held;
        unique case (mode)
            OUT_DRIVE: par_en = 1'b1;
            OUT_HIZ:   par_en = 1'b0;
            default:   par_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/ser_latch_shifter.sv
module ser_latch_shifter #(
    parameter int unsigned WIDTH = ssr_pkg::SSR_WIDTH_DEFAULT
) (
    input  logic             sdi,
    input  logic             shift_clk,
    input  logic             store_clk,
    input  logic             rst_n,
    input  logic             oe_n,
    output logic [WIDTH-1:0] par_q,
    output logic             par_en,
    output logic             cas_out
);
    localparam int unsigned LAST = WIDTH - 1;

    logic [WIDTH-1:0] stages;
    logic [WIDTH-1:0] held;

    ssr_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .clk    (shift_clk),
        .rst_n  (rst_n),
        .sdi    (sdi),
        .stages (stages)
    );

    ssr_hold_reg #(.WIDTH(WIDTH)) u_hold (
        .clk (store_clk),
        .d   (stages),
        .q   (held)
    );

    ssr_out_stage #(.WIDTH(WIDTH)) u_out (
        .oe_n   (oe_n),
        .held   (held),
        .par_q  (par_q),
        .par_en (par_en)
    );

    assign cas_out = stages[LAST];

    AST_CASCADE_LAG: assert property (@(posedge shift_clk) disable iff (!rst_n)
        rst_n |=> (cas_out == $past(stages[LAST-1])));  // R3

    AST_STORE_COPY: assert property (@(posedge store_clk)
        rst_n |=> (par_q == $past(stages)));  // R2

    AST_STORE_ZERO_IN_RESET: assert property (@(posedge store_clk)
        !rst_n |=> (par_q == '0));  // R5
endmodule

// File: tb/ser_latch_shifter_bench.sv
module ser_latch_shifter_bench;
    localparam int W = 8;
    localparam int NVEC = 16;
    // stimulus entries: {sdi, shift, store, oe_n}
    localparam logic [3:0] VEC [NVEC] = '{
        4'b1100, 4'b0100, 4'b1100, 4'b1110, 4'b0010, 4'b1101,
        4'b0111, 4'b1100, 4'b1100, 4'b0110, 4'b0011, 4'b1100,
        4'b0101, 4'b0010, 4'b1110, 4'b0000
    };

    logic clk = 1'b0;
    logic sdi = 1'b0, shift_clk = 1'b0, store_clk = 1'b0, rst_n = 1'b0, oe_n = 1'b1;
    logic [W-1:0] pq_lo, pq_hi;
    logic pen_lo, pen_hi, cas_lo, cas_hi;

    logic [2*W-1:0] m_sr = '0;
    logic [W-1:0] m_st_lo = '0, m_st_hi = '0;
    int checks = 0, fails = 0, cyc = 0;

    always #2 clk = ~clk;

    ser_latch_shifter #(.WIDTH(W)) u_ser_latch_shifter (
        .sdi(sdi), .shift_clk(shift_clk), .store_clk(store_clk), .rst_n(rst_n),
        .oe_n(oe_n), .par_q(pq_lo), .par_en(pen_lo), .cas_out(cas_lo));

    ser_latch_shifter #(.WIDTH(W)) u_ser_latch_shifter_hi (
        .sdi(cas_lo), .shift_clk(shift_clk), .store_clk(store_clk), .rst_n(rst_n),
        .oe_n(oe_n), .par_q(pq_hi), .par_en(pen_hi), .cas_out(cas_hi));

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic d, input logic sh, input logic st, input logic oe);
        @(negedge clk);
        sdi = d;
        oe_n = oe;
        @(posedge clk);
        if (st) begin
            store_clk = 1'b1;
            m_st_lo = rst_n ? m_sr[W-1:0] : '0;
            m_st_hi = rst_n ? m_sr[2*W-1:W] : '0;
        end
        if (sh) begin
            shift_clk = 1'b1;
            m_sr = rst_n ? {m_sr[2*W-2:0], d} : '0;
        end
        @(negedge clk);
        shift_clk = 1'b0;
        store_clk = 1'b0;
        #1;
    endtask

    task automatic check_all(input string req);
        check({req, " par_q"}, {8'h0, pq_lo}, {8'h0, m_st_lo});
        check({req, " cas_out"}, {15'h0, cas_lo}, {15'h0, m_sr[W-1]});
        check("R6 par_en", {15'h0, pen_lo}, {15'h0, ~oe_n});
    endtask

    initial begin
        // reset: chain cleared, store under reset loads zeros
        step(1'b1, 1'b1, 1'b0, 1'b1);
        check("R4 reset cas_out", {15'h0, cas_lo}, 16'h0);
        step(1'b1, 1'b0, 1'b1, 1'b1);
        check("R5 store in reset", {pq_hi, pq_lo}, 16'h0);
        check("R6 disabled", {15'h0, pen_lo}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R3 R7 table walk
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
            check_all("R1 R2 R3 R7 table");
        end

        // R7 tied clocks: storage lags by one shift
        for (int i = 0; i < W; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b1, 1'b0);
        check("R7 tied lag", {8'h0, pq_lo}, 16'h00FF);
        check("R3 cas after shift", {15'h0, cas_lo}, 16'h1);

        // R6 enable toggles leave par_q and cas_out alone
        @(negedge clk); oe_n = 1'b1; #1;
        check("R6 hiz par_q", {8'h0, pq_lo}, 16'h00FF);
        check("R6 hiz cas", {15'h0, cas_lo}, 16'h1);
        check("R6 hiz en", {15'h0, pen_lo}, 16'h0);
        @(negedge clk); oe_n = 1'b0; #1;
        check("R6 drive en", {15'h0, pen_lo}, 16'h1);

        // R4 async reset keeps storage; R5 store under reset zeros it
        @(negedge clk); rst_n = 1'b0; #1;
        m_sr = '0;
        check("R4 async clear", {15'h0, cas_lo}, 16'h0);
        check("R4 storage kept", {8'h0, pq_lo}, 16'h00FF);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        check("R4 storage kept after edge", {8'h0, pq_lo}, 16'h00FF);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        check("R5 zeros stored", {8'h0, pq_lo}, 16'h0);
        @(negedge clk); rst_n = 1'b1;

        // R8 16-bit chain
        for (int i = 15; i >= 0; i--) step(16'hA5C3 >> i, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        check("R8 chain word", {pq_hi, pq_lo}, 16'hA5C3);
        check("R8 chain model", {pq_hi, pq_lo}, {m_st_hi, m_st_lo});
        check("R8 last cas", {15'h0, cas_hi}, 16'h1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule